// File: doc/BRIEF.md
# Table-Seeded CORDIC Sine/Cosine Synthesizer

This block generates a continuous stream of sine and cosine samples from a programmable frequency word. A phase register advances by the frequency word on every enabled clock. Each phase value is turned into a quadrant, a coarse segment within that quadrant, and a fine residual angle. The coarse segment picks a precomputed starting vector. That vector already sits at the segment centre and is pre-scaled so that the result comes out at full amplitude. A short pipeline of shift-and-add micro-rotations then turns the vector by the residual angle. A final stage converts the redundant result to ordinary two's complement, rounds it, and maps it into the right quadrant.

Because the starting vector replaces the widest rotations, only six micro-rotation stages remain. Each stage keeps its x and y coordinates as a sum/carry pair, so no carry ripples across the word inside a stage. The pair is resolved once, in the output stage. One new sample enters the pipeline on every clock. Its result leaves with a valid flag after a fixed latency.

Top module: `cordic_dds`

## Requirements
- R1: While rst_i is high at a rising edge, every pipeline register clears. After that edge valid_o is 0 and sin_o and cos_o are 0. The phase register restarts at 0, so the first sample taken after reset uses phase 0.
- R2: At each rising edge with en_i high, the block takes a sample at the current 24-bit phase P. It then sets the phase to (P + fcw_i) mod 2^24.
- R3: A sample taken at rising edge k appears with valid_o = 1 just after edge k+7, which gives eight register stages. At any other time valid_o is 1 only for other sampled edges.
- R4: For a valid sample with phase P, cos_o is within ±40 LSB of round(A·cos(2πP/2^24)), where A = 2^(OUT_W-1) - 8 = 8184.
- R5: For a valid sample with phase P, sin_o is within ±40 LSB of round(A·sin(2πP/2^24)).
- R6: Phase bits [23:22] select the quadrant, and bits [21:20] select one of four starting vectors at the segment centres. Outputs stay accurate in all four quadrants and exactly on segment and quadrant boundaries.
- R7: Samples taken on back-to-back enabled edges come out on back-to-back cycles, one per clock.
- R8: The phase wraps modulo 2^24. A frequency word of 2^23 or more therefore acts as a negative or aliased frequency.
- R9: A valid output never carries the most negative code -2^(OUT_W-1). For a valid output, the larger of |sin_o| and |cos_o| is at least A·0.707 - 48.
- R10: Whenever valid_o is 0, sin_o and cos_o are both 0.
- R11: An edge with en_i low takes no sample and leaves the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Take a sample and advance the phase on this edge |
| fcw_i | input | 24 | Frequency word added to the phase |
| sin_o | output | 14 | Sine sample, two's complement |
| cos_o | output | 14 | Cosine sample, two's complement |
| valid_o | output | 1 | sin_o and cos_o hold a sample |

## Verification
The phase register can wrap past 2^24 on the same edge that a sample crosses from one quadrant or segment into the next. A mistake in either the modulo step or the quadrant fold could therefore hide inside the other. The bench provokes this with frequency words above 2^23 and with a word of exactly 2^20, which lands every sample on a segment boundary. A reset is also applied while samples are still in flight, so the flush and the restart of the phase fall on the same edge. In every case a queue-based model in the bench predicts the phase and the valid flag for each cycle. Each sample is then judged against real-valued sine and cosine within the stated tolerance.

// File: rtl/cordic_dds_pkg.sv
package cordic_dds_pkg;

    localparam real PI = 3.14159265358979323846;

    function automatic integer round_real(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    function automatic real pow2_neg(input integer k);
        real r;
        r = 1.0;
        for (int n = 0; n < k; n++) r = r / 2.0;
        return r;
    endfunction

    // Gain of the micro-rotations that remain after the table seed
    function automatic real stage_gain(input integer nst, input integer first);
        real g;
        g = 1.0;
        for (int k = first; k < first + nst; k++) begin
            g = g * $sqrt(1.0 + pow2_neg(2 * k));
        end
        return g;
    endfunction

    // atan(2^-k) expressed in angle units, 2^circle_log2 units per turn
    function automatic integer atan_units(input integer k, input integer circle_log2);
        real turn;
        turn = 1.0;
        for (int n = 0; n < circle_log2; n++) turn = turn * 2.0;
        return round_real($atan(pow2_neg(k)) * turn / (2.0 * PI));
    endfunction

    // Start vector at the centre of segment j, pre-divided by the stage gain
    function automatic integer start_coord(input integer j, input integer seg_w,
                                           input integer amp, input integer nst,
                                           input integer first, input bit want_sin);
        real ang;
        real r;
        ang = (j + 0.5) * (PI / 2.0) * pow2_neg(seg_w);
        r   = amp / stage_gain(nst, first);
        return want_sin ? round_real(r * $sin(ang)) : round_real(r * $cos(ang));
    endfunction

endpackage

// File: rtl/cordic_dds_phase.sv
module cordic_dds_phase #(
    parameter int PHASE_W  = 24,
    parameter int SEG_W    = 2,
    parameter int RES_W    = 12,
    parameter int ZFRAC    = 2,
    parameter int INT_W    = 32,
    parameter int ZW       = 16,
    parameter int AMP_SC   = 130944,
    parameter int NSTAGE   = 6,
    parameter int FIRST_SH = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic [PHASE_W-1:0]      fcw_i,
    output logic signed [INT_W-1:0] x_o,
    output logic signed [INT_W-1:0] y_o,
    output logic signed [ZW-1:0]    z_o,
    output logic [1:0]              quad_o,
    output logic                    vld_o
);
    localparam int SEG_N = 2 ** SEG_W;
    localparam logic [ZW-1:0] RES_HALF = ZW'(2 ** (RES_W - 1));
    localparam logic [ZW-1:0] Z_ROUND  = ZW'(2 ** (ZFRAC - 1));

    typedef struct packed {
        logic [PHASE_W-1:0]      acc;
        logic signed [INT_W-1:0] x;
        logic signed [INT_W-1:0] y;
        logic signed [ZW-1:0]    z;
        logic [1:0]              quad;
        logic                    vld;
    } ph_t;

    ph_t ph_d, ph_q;

    logic signed [INT_W-1:0] seed_x [SEG_N];
    logic signed [INT_W-1:0] seed_y [SEG_N];

    for (genvar j = 0; j < SEG_N; j++) begin : g_seed
        localparam int SX = cordic_dds_pkg::start_coord(j, SEG_W, AMP_SC, NSTAGE, FIRST_SH, 1'b0);
        localparam int SY = cordic_dds_pkg::start_coord(j, SEG_W, AMP_SC, NSTAGE, FIRST_SH, 1'b1);
        assign seed_x[j] = INT_W'(SX);
        assign seed_y[j] = INT_W'(SY);
    end

    logic [SEG_W-1:0] seg;
    logic [RES_W-1:0] res;
    logic [ZW-1:0]    z_off;

    always_comb begin
        ph_d  = ph_q;
        seg   = ph_q.acc[PHASE_W-3 -: SEG_W];
        res   = ph_q.acc[PHASE_W-3-SEG_W -: RES_W];
        z_off = ZW'(res) - RES_HALF;
        if (en_i) ph_d.acc = ph_q.acc + fcw_i;
        ph_d.x    = seed_x[seg];
        ph_d.y    = seed_y[seg];
        ph_d.z    = (z_off << ZFRAC) + Z_ROUND;
        ph_d.quad = ph_q.acc[PHASE_W-1 -: 2];
        ph_d.vld  = en_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ph_q <= '0;
        else       ph_q <= ph_d;
    end

    assign x_o    = ph_q.x;
    assign y_o    = ph_q.y;
    assign z_o    = ph_q.z;
    assign quad_o = ph_q.quad;
    assign vld_o  = ph_q.vld;

endmodule

// File: rtl/cordic_dds_stage.sv
module cordic_dds_stage #(
    parameter int INT_W = 32,
    parameter int ZW    = 16,
    parameter int SHIFT = 3,
    parameter int ATAN  = 5188
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic signed [INT_W-1:0] xs_i,
    input  logic signed [INT_W-1:0] xc_i,
    input  logic signed [INT_W-1:0] ys_i,
    input  logic signed [INT_W-1:0] yc_i,
    input  logic signed [ZW-1:0]    z_i,
    input  logic [1:0]              quad_i,
    input  logic                    vld_i,
    output logic signed [INT_W-1:0] xs_o,
    output logic signed [INT_W-1:0] xc_o,
    output logic signed [INT_W-1:0] ys_o,
    output logic signed [INT_W-1:0] yc_o,
    output logic signed [ZW-1:0]    z_o,
    output logic [1:0]              quad_o,
    output logic                    vld_o
);
    typedef struct packed {
        logic signed [INT_W-1:0] xs;
        logic signed [INT_W-1:0] xc;
        logic signed [INT_W-1:0] ys;
        logic signed [INT_W-1:0] yc;
        logic signed [ZW-1:0]    z;
        logic [1:0]              quad;
        logic                    vld;
    } rot_t;

    rot_t rot_d, rot_q;

    // 3:2 compressor; cin fills the empty carry LSB
    function automatic logic [2*INT_W-1:0] csa3(input logic [INT_W-1:0] a,
                                                input logic [INT_W-1:0] b,
                                                input logic [INT_W-1:0] c,
                                                input logic cin);
        logic [INT_W-1:0] s;
        logic [INT_W-1:0] m;
        s = a ^ b ^ c;
        m = (a & b) | (a & c) | (b & c);
        return {s, m[INT_W-2:0], cin};
    endfunction

    logic                    ccw;
    logic signed [INT_W-1:0] ysh_s, ysh_c, xsh_s, xsh_c;
    logic [INT_W-1:0]        tx_s, tx_c, ty_s, ty_c;
    logic [INT_W-1:0]        s1, c1, s2, c2;

    always_comb begin
        rot_d = rot_q;
        ccw   = ~z_i[ZW-1];
        ysh_s = ys_i >>> SHIFT;
        ysh_c = yc_i >>> SHIFT;
        xsh_s = xs_i >>> SHIFT;
        xsh_c = xc_i >>> SHIFT;
        tx_s  = ccw ? ~ysh_s : ysh_s;
        tx_c  = ccw ? ~ysh_c : ysh_c;
        ty_s  = ccw ? xsh_s : ~xsh_s;
        ty_c  = ccw ? xsh_c : ~xsh_c;

        {s1, c1} = csa3(xs_i, xc_i, tx_s, ccw);
        {s2, c2} = csa3(s1, c1, tx_c, ccw);
        rot_d.xs = s2;
        rot_d.xc = c2;

        {s1, c1} = csa3(ys_i, yc_i, ty_s, ~ccw);
        {s2, c2} = csa3(s1, c1, ty_c, ~ccw);
        rot_d.ys = s2;
        rot_d.yc = c2;

        rot_d.z    = ccw ? z_i - ZW'(ATAN) : z_i + ZW'(ATAN);
        rot_d.quad = quad_i;
        rot_d.vld  = vld_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) rot_q <= '0;
        else       rot_q <= rot_d;
    end

    assign xs_o   = rot_q.xs;
    assign xc_o   = rot_q.xc;
    assign ys_o   = rot_q.ys;
    assign yc_o   = rot_q.yc;
    assign z_o    = rot_q.z;
    assign quad_o = rot_q.quad;
    assign vld_o  = rot_q.vld;

endmodule

// File: rtl/cordic_dds_out.sv
module cordic_dds_out #(
    parameter int INT_W = 32,
    parameter int GUARD = 4,
    parameter int OUT_W = 14
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic signed [INT_W-1:0] xs_i,
    input  logic signed [INT_W-1:0] xc_i,
    input  logic signed [INT_W-1:0] ys_i,
    input  logic signed [INT_W-1:0] yc_i,
    input  logic [1:0]              quad_i,
    input  logic                    vld_i,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o,
    output logic                    valid_o
);
    localparam logic signed [INT_W-1:0] HALF_LSB = INT_W'(2 ** (GUARD - 1));

    typedef struct packed {
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
        logic                    vld;
    } out_t;

    out_t out_d, out_q;

    logic signed [INT_W-1:0] xsum, ysum;
    logic signed [OUT_W-1:0] cr, sr;

    always_comb begin
        xsum = xs_i + xc_i;
        ysum = ys_i + yc_i;
        cr   = OUT_W'((xsum + HALF_LSB) >>> GUARD);
        sr   = OUT_W'((ysum + HALF_LSB) >>> GUARD);
        out_d.vld = vld_i;
        unique case (quad_i)
            2'd0:    begin out_d.c =  cr; out_d.s =  sr; end
            2'd1:    begin out_d.c = -sr; out_d.s =  cr; end
            2'd2:    begin out_d.c = -cr; out_d.s = -sr; end
            default: begin out_d.c =  sr; out_d.s = -cr; end
        endcase
        if (!vld_i) begin
            out_d.c = '0;
            out_d.s = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) out_q <= '0;
        else       out_q <= out_d;
    end

    assign sin_o   = out_q.s;
    assign cos_o   = out_q.c;
    assign valid_o = out_q.vld;

endmodule

// File: rtl/cordic_dds.sv
module cordic_dds #(
    parameter int PHASE_W     = 24,
    parameter int SEG_W       = 2,
    parameter int RES_W       = 12,
    parameter int ZFRAC       = 2,
    parameter int OUT_W       = 14,
    parameter int GUARD       = 4,
    parameter int NSTAGE      = 6,
    parameter int FIRST_SH    = 3,
    parameter int AMP_BACKOFF = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic [PHASE_W-1:0]      fcw_i,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o,
    output logic                    valid_o
);
    localparam int DATA_W      = OUT_W + GUARD;
    localparam int INT_W       = DATA_W + 2 * NSTAGE + 2;
    localparam int ZW          = RES_W + ZFRAC + 2;
    localparam int AMP         = 2 ** (OUT_W - 1) - AMP_BACKOFF;
    localparam int AMP_SC      = AMP * (2 ** GUARD);
    localparam int CIRCLE_LOG2 = 2 + SEG_W + RES_W + ZFRAC;

    logic signed [INT_W-1:0] xs [NSTAGE+1];
    logic signed [INT_W-1:0] xc [NSTAGE+1];
    logic signed [INT_W-1:0] ys [NSTAGE+1];
    logic signed [INT_W-1:0] yc [NSTAGE+1];
    logic signed [ZW-1:0]    zz [NSTAGE+1];
    logic [1:0]              qd [NSTAGE+1];
    logic                    vd [NSTAGE+1];

    cordic_dds_phase #(
        .PHASE_W(PHASE_W), .SEG_W(SEG_W), .RES_W(RES_W), .ZFRAC(ZFRAC),
        .INT_W(INT_W), .ZW(ZW), .AMP_SC(AMP_SC), .NSTAGE(NSTAGE), .FIRST_SH(FIRST_SH)
    ) u_phase (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .fcw_i(fcw_i),
        .x_o(xs[0]), .y_o(ys[0]), .z_o(zz[0]), .quad_o(qd[0]), .vld_o(vd[0])
    );
    assign xc[0] = '0;
    assign yc[0] = '0;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_rot
        localparam int ATAN_U = cordic_dds_pkg::atan_units(FIRST_SH + i, CIRCLE_LOG2);
        cordic_dds_stage #(
            .INT_W(INT_W), .ZW(ZW), .SHIFT(FIRST_SH + i), .ATAN(ATAN_U)
        ) u_stage (
            .clk_i(clk_i), .rst_i(rst_i),
            .xs_i(xs[i]), .xc_i(xc[i]), .ys_i(ys[i]), .yc_i(yc[i]),
            .z_i(zz[i]), .quad_i(qd[i]), .vld_i(vd[i]),
            .xs_o(xs[i+1]), .xc_o(xc[i+1]), .ys_o(ys[i+1]), .yc_o(yc[i+1]),
            .z_o(zz[i+1]), .quad_o(qd[i+1]), .vld_o(vd[i+1])
        );
    end

    cordic_dds_out #(
        .INT_W(INT_W), .GUARD(GUARD), .OUT_W(OUT_W)
    ) u_out (
        .clk_i(clk_i), .rst_i(rst_i),
        .xs_i(xs[NSTAGE]), .xc_i(xc[NSTAGE]), .ys_i(ys[NSTAGE]), .yc_i(yc[NSTAGE]),
        .quad_i(qd[NSTAGE]), .vld_i(vd[NSTAGE]),
        .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o)
    );

    logic unused_z;
    assign unused_z = ^zz[NSTAGE];

endmodule

// File: rtl/cordic_dds_chk.sv
module cordic_dds_chk #(
    parameter int PHASE_W     = 24,
    parameter int OUT_W       = 14,
    parameter int NSTAGE      = 6,
    parameter int AMP_BACKOFF = 8
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    en_i,
    input logic [PHASE_W-1:0]      fcw_i,
    input logic signed [OUT_W-1:0] sin_o,
    input logic signed [OUT_W-1:0] cos_o,
    input logic                    valid_o
);
    localparam int LAT   = NSTAGE + 2;
    localparam int AMP   = 2 ** (OUT_W - 1) - AMP_BACKOFF;
    localparam int FLOOR = AMP * 707 / 1000 - 48;
    localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic [LAT-1:0] en_hist;
    always_ff @(posedge clk_i) begin
        if (rst_i) en_hist <= '0;
        else       en_hist <= {en_hist[LAT-2:0], en_i};
    end

    int s_mag, c_mag, peak;
    always_comb begin
        s_mag = (sin_o < 0) ? -int'(sin_o) : int'(sin_o);
        c_mag = (cos_o < 0) ? -int'(cos_o) : int'(cos_o);
        peak  = (s_mag > c_mag) ? s_mag : c_mag;
    end

    logic unused_fcw;
    assign unused_fcw = ^fcw_i;

    // R1: reset flushes the output stage
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (!valid_o && sin_o == '0 && cos_o == '0));

    // R3, R7: valid follows the sampled enable by the pipeline depth
    assert_valid_latency_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o == en_hist[LAT-1]);

    // R9: no most-negative code on a valid sample
    assert_no_most_neg_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (sin_o != MOST_NEG && cos_o != MOST_NEG));

    // R9: vector length stays near the full amplitude
    assert_amplitude_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (peak >= FLOOR));

    // R10: idle outputs read zero
    assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> (sin_o == '0 && cos_o == '0));

endmodule

bind cordic_dds cordic_dds_chk #(
    .PHASE_W(PHASE_W), .OUT_W(OUT_W), .NSTAGE(NSTAGE), .AMP_BACKOFF(AMP_BACKOFF)
) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .fcw_i(fcw_i),
    .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o)
);

// File: tb/cordic_dds_tb_top.sv
`timescale 1ns/1ps
module cordic_dds_tb_top;
    localparam int  OUT_W = 14;
    localparam int  LAT   = 8;
    localparam int  AMP   = 8184;
    localparam int  TOL   = 40;
    localparam real TWO_PI = 6.28318530717958647692;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                    rst = 1'b1;
    logic                    en  = 1'b0;
    logic [23:0]             fcw = '0;
    logic signed [OUT_W-1:0] sin_o, cos_o;
    logic                    valid_o;

    cordic_dds dut_i (
        .clk_i(clk), .rst_i(rst), .en_i(en), .fcw_i(fcw),
        .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o)
    );

    typedef struct {
        bit          v;
        int unsigned ph;
    } exp_t;

    exp_t        pend[$];
    int unsigned phase_m = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    endfunction

    task automatic judge(input string req, input int got, input int exp, input int tol);
        int diff;
        n_cmp++;
        diff = got - exp;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (tol %0d)", req, got, exp, tol);
        end
    endtask

    task automatic check_out(input exp_t e);
        real ang;
        judge("R3 valid_o", int'(valid_o), int'(e.v), 0);
        if (e.v) begin
            ang = TWO_PI * real'(e.ph) / 16777216.0;
            judge("R4 cos_o", int'(cos_o), rnd(AMP * $cos(ang)), TOL);
            judge("R5 sin_o", int'(sin_o), rnd(AMP * $sin(ang)), TOL);
        end else begin
            judge("R10 idle cos_o", int'(cos_o), 0, 0);
            judge("R10 idle sin_o", int'(sin_o), 0, 0);
        end
    endtask

    // Drive one edge; the model mirrors R1, R2, R8, R11
    task automatic step(input bit r, input bit e, input logic [23:0] f);
        exp_t n;
        @(negedge clk);
        if (pend.size() == LAT) check_out(pend.pop_front());
        rst = r;
        en  = e;
        fcw = f;
        n.v  = e && !r;
        n.ph = phase_m;
        if (r) begin
            foreach (pend[k]) pend[k].v = 1'b0;
            phase_m = 0;
        end else if (e) begin
            phase_m = (phase_m + f) & 32'h00FF_FFFF;
        end
        pend.push_back(n);
    endtask

    task automatic run(input int n, input logic [23:0] f);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, f);
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, '0);
        // R6: every sample on a segment or quadrant boundary
        run(40, 24'h100000);
        // R7: back-to-back samples at a moderate rate
        run(600, 24'h012345);
        // R8: word above 2^23, aliased rotation with wrap
        run(600, 24'h9ABCDE);
        // R8: small negative frequency
        run(300, 24'hFFF123);
        // R11: gaps in the enable
        for (int i = 0; i < 400; i++) step(1'b0, (i % 3) != 0, 24'h054321);
        // R2: zero word holds the phase
        run(20, 24'h000000);
        // R6: odd word near a quarter turn per sample
        run(200, 24'h3FFFFF);
        // R1: reset with samples in flight, then restart from phase 0
        run(5, 24'h0ABCDE);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 24'h0ABCDE);
        run(100, 24'h0ABCDE);
        // drain
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule